// File: doc/BRIEF.md
# Per-Pin Input Event Interrupt Unit

This unit watches a bank of general-purpose input pins and turns selected activity on them into interrupt requests. Each pin first passes through a synchronizer. Its own four-bit condition code then chooses one of five trigger types: a low-to-high transition, a high-to-low transition, a transition in either direction, a steady high level or a steady low level. A qualifying event sets that pin's pending latch, but only while the pin's input gate is open. Software reads the pending latches in two ways: as raw status, or ANDed with a per-pin unmask state. It clears them by writing ones.

The mask state is changed through two write-one strobes, one that unmasks and one that masks. The pins are split into a lower and an upper half, and each half drives its own interrupt request line. When software changes a pin's condition, it closes the gate, writes the new code, clears the pin's pending bit and then reopens the gate. The unit latches no spurious event during that sequence.

Top module: `pev_top`

## Requirements
- R1: After reset, every condition code, gate bit and pending bit is 0, every pin is masked (0x1C reads all ones), both request lines are low and the status reads at 0x20 and 0x24 return 0.
- R2: Pin n's condition code lives in the register at 0x40 + 4*(n/8), bits 4*(n%8)+3 down to 4*(n%8), and reads back as written. The gate register at 0x14 is read/write with one bit per pin.
- R3: Code 0 sets the pending bit on a low-to-high transition. For all edge codes, the bit stays set after the pin returns, until it is cleared.
- R4: Code 1 triggers on a high-to-low transition. Code 4 triggers on a transition in either direction.
- R5: Code 2 (level high) and code 3 (level low) set the pending bit while the level holds. A clear wins in the cycle it is written, and the bit is set again on the following clock if the level still holds. Once the level is gone, the bit stays clear after a clear.
- R6: A pin whose gate bit is 0 never gets a new pending event. A pending bit that is already set is kept when the gate closes.
- R7: Writing a 1 in a bit at 0x18 unmasks that pin. Writing a 1 at 0x1C masks it. Zero bits leave the mask unchanged, and 0x1C reads the mask with 1 meaning masked.
- R8: Writing a 1 in a bit at 0x28 clears that pin's pending bit. Zero bits have no effect.
- R9: 0x20 reads the raw pending bits. 0x24 reads the pending bits ANDed with the unmask state.
- R10: Request 0 is the OR of the unmasked pending bits of the lower half of the pins, and request 1 is the same for the upper half. Each line follows one clock after the pending and mask state.
- R11: A pin change presented before a clock edge sets the pending bit on the third rising edge (two synchronizer stages plus the latch), and the request line on the fourth.
- R12: Codes 5, 6 and 7 never produce an event. Bit 3 of a code is stored and read back, but detection follows bits 2:0 only, so code 8 acts as a low-to-high trigger.
- R13: Closing the gate, writing a new code, clearing the pin and reopening the gate latches no event when the pin holds still, even if the old and new codes disagree about the pin's current level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | 32 | Asynchronous pin inputs |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after the access |
| irq_o | output | 2 | Request lines: bit 0 for the lower half of the pins, bit 1 for the upper half |

## Verification
A pin change reaches the pending latch on the third clock edge after it is driven and reaches the request line on the fourth. The bench drives the pins and the bus on falling edges and samples one nanosecond after rising edges. The latency check counts exactly three and then four edges.

A write to a mask or clear register takes effect at the edge that accepts the write, and the request lines respond one edge later. A read returns the state held just before the edge that accepts the read. For this reason, a read issued right after clearing a level-triggered pin returns 0, and the following read returns 1. The bench checks both reads. Where the bench checks only the final state, it waits at least four cycles before reading.

// File: rtl/pev_pkg.sv
package pev_pkg;
  localparam int OFF_GATE     = 'h14;
  localparam int OFF_UNMASK   = 'h18;
  localparam int OFF_MASK     = 'h1C;
  localparam int OFF_RAW      = 'h20;
  localparam int OFF_MSTAT    = 'h24;
  localparam int OFF_CLEAR    = 'h28;
  localparam int OFF_COND0    = 'h40;
  localparam int COND_W       = 4;

  typedef enum logic [2:0] {
    COND_RISE = 3'd0,
    COND_FALL = 3'd1,
    COND_HIGH = 3'd2,
    COND_LOW  = 3'd3,
    COND_ANY  = 3'd4
  } cond_e;
endpackage

// File: rtl/pev_sync.sv
module pev_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pev_detect.sv
module pev_detect
  import pev_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_PINS-1:0]        pin_s_i,
  input  logic [N_PINS*COND_W-1:0] cond_i,
  input  logic [N_PINS-1:0]        gate_i,
  input  logic [N_PINS-1:0]        clr_i,
  output logic [N_PINS-1:0]        pend_o
);
  logic [N_PINS-1:0] prev_q;
  logic [N_PINS-1:0] event_w;
  logic [N_PINS-1:0] pend_q;
  logic [N_PINS-1:0] unused_async;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= pin_s_i;
  end

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    logic [2:0] kind;
    assign kind = cond_i[g*COND_W +: 3];
    assign unused_async[g] = cond_i[g*COND_W + 3];

    always_comb begin
      case (kind)
        COND_RISE: event_w[g] = pin_s_i[g] & ~prev_q[g];
        COND_FALL: event_w[g] = ~pin_s_i[g] & prev_q[g];
        COND_HIGH: event_w[g] = pin_s_i[g];
        COND_LOW:  event_w[g] = ~pin_s_i[g];
        COND_ANY:  event_w[g] = pin_s_i[g] ^ prev_q[g];
        default:   event_w[g] = 1'b0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst)            pend_q[g] <= 1'b0;
      else if (clr_i[g])  pend_q[g] <= 1'b0;
      else if (gate_i[g] && event_w[g]) pend_q[g] <= 1'b1;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/pev_regs.sv
module pev_regs
  import pev_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_en,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic [N_PINS-1:0]        pend_i,
  output logic [N_PINS-1:0]        gate_o,
  output logic [N_PINS-1:0]        mask_o,
  output logic [N_PINS*COND_W-1:0] cond_o,
  output logic [N_PINS-1:0]        clr_o
);
  localparam int FLD_PER_REG = DATA_W / COND_W;
  localparam int N_CREG      = N_PINS / FLD_PER_REG;
  localparam int CIDX_W      = (N_CREG > 1) ? $clog2(N_CREG) : 1;

  logic [N_PINS-1:0] gate_q;
  logic [N_PINS-1:0] mask_q;
  logic [DATA_W-1:0] cond_q [N_CREG];
  logic [DATA_W-1:0] rdata_q;
  logic              cond_hit;
  logic [CIDX_W-1:0] cond_idx;
  logic              wr, rd;

  assign wr = bus_en & bus_we;
  assign rd = bus_en & ~bus_we;

  always_comb begin
    cond_hit = 1'b0;
    cond_idx = '0;
    for (int r = 0; r < N_CREG; r++) begin
      if (bus_addr == ADDR_W'(OFF_COND0 + 4*r)) begin
        cond_hit = 1'b1;
        cond_idx = CIDX_W'(r);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= '0;
      mask_q <= '1;
    end else if (wr) begin
      if (bus_addr == ADDR_W'(OFF_GATE))   gate_q <= bus_wdata[N_PINS-1:0];
      if (bus_addr == ADDR_W'(OFF_UNMASK)) mask_q <= mask_q & ~bus_wdata[N_PINS-1:0];
      if (bus_addr == ADDR_W'(OFF_MASK))   mask_q <= mask_q | bus_wdata[N_PINS-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < N_CREG; r++) cond_q[r] <= '0;
    end else if (wr && cond_hit) begin
      cond_q[cond_idx] <= bus_wdata;
    end
  end

  assign clr_o = (wr && bus_addr == ADDR_W'(OFF_CLEAR)) ? bus_wdata[N_PINS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd) begin
      if (cond_hit) rdata_q <= cond_q[cond_idx];
      else begin
        case (int'(bus_addr))
          OFF_GATE:  rdata_q <= DATA_W'(gate_q);
          OFF_MASK:  rdata_q <= DATA_W'(mask_q);
          OFF_RAW:   rdata_q <= DATA_W'(pend_i);
          OFF_MSTAT: rdata_q <= DATA_W'(pend_i & ~mask_q);
          default:   rdata_q <= '0;
        endcase
      end
    end
  end

  for (genvar r = 0; r < N_CREG; r++) begin : g_cond
    assign cond_o[r*DATA_W +: DATA_W] = cond_q[r];
  end

  assign gate_o    = gate_q;
  assign mask_o    = mask_q;
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/pev_top.sv
module pev_top
  import pev_pkg::*;
#(
  parameter int N_PINS      = 32,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] pins_i,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [1:0]        irq_o
);
  localparam int N_IRQ = 2;
  localparam int HALF  = N_PINS / N_IRQ;

  logic [N_PINS-1:0]        pin_s_w;
  logic [N_PINS-1:0]        pend_w;
  logic [N_PINS-1:0]        gate_w;
  logic [N_PINS-1:0]        mask_w;
  logic [N_PINS-1:0]        clr_w;
  logic [N_PINS*COND_W-1:0] cond_w;
  logic [N_IRQ-1:0]         irq_q;

  pev_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d_i(pins_i), .q_o(pin_s_w)
  );

  pev_regs #(.N_PINS(N_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pend_i(pend_w), .gate_o(gate_w), .mask_o(mask_w),
    .cond_o(cond_w), .clr_o(clr_w)
  );

  pev_detect #(.N_PINS(N_PINS)) detect_i (
    .clk(clk), .rst(rst), .pin_s_i(pin_s_w), .cond_i(cond_w),
    .gate_i(gate_w), .clr_i(clr_w), .pend_o(pend_w)
  );

  for (genvar h = 0; h < N_IRQ; h++) begin : g_irq
    always_ff @(posedge clk) begin
      if (rst) irq_q[h] <= 1'b0;
      else     irq_q[h] <= |(pend_w[h*HALF +: HALF] & ~mask_w[h*HALF +: HALF]);
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/pev_checker.sv
module pev_checker
  import pev_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [N_PINS-1:0] pend,
  input logic [N_PINS-1:0] mask,
  input logic [N_PINS-1:0] gate,
  input logic [1:0]        irq
);
  localparam int HALF = N_PINS / 2;

  a_r10_irq_low: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq[0] == $past(|(pend[HALF-1:0] & ~mask[HALF-1:0])));

  a_r10_irq_high: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq[1] == $past(|(pend[N_PINS-1:HALF] & ~mask[N_PINS-1:HALF])));

  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_we && bus_addr == ADDR_W'(OFF_CLEAR))
    |=> ((pend & $past(bus_wdata[N_PINS-1:0])) == '0));

  a_r6_gate: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(gate)) == '0));

  a_r7_mask_set: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_we && bus_addr == ADDR_W'(OFF_MASK))
    |=> ((mask & $past(bus_wdata[N_PINS-1:0])) == $past(bus_wdata[N_PINS-1:0])));

  a_r7_unmask: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_we && bus_addr == ADDR_W'(OFF_UNMASK))
    |=> ((mask & $past(bus_wdata[N_PINS-1:0])) == '0));

  a_r9_masked_read: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !bus_we && bus_addr == ADDR_W'(OFF_MSTAT))
    |=> bus_rdata == DATA_W'($past(pend & ~mask)));
endmodule

bind pev_top pev_checker #(.N_PINS(N_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pend(pend_w), .mask(mask_w),
  .gate(gate_w), .irq(irq_o)
);

// File: tb/pev_top_tb_top.sv
`timescale 1ns/1ps
module pev_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pins = '0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;
  int          n_checks = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  pev_top dut_i (
    .clk(clk), .rst(rst), .pins_i(pins), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_pins(input logic [31:0] v);
    @(negedge clk);
    pins = v;
  endtask

  task automatic tidy();
    wr(8'h14, 32'h0);
    set_pins(32'h0);
    idle(4);
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq", {30'h0, irq}, 32'h0);
    rd(8'h20, v); check("R1 raw", v, 32'h0);
    rd(8'h24, v); check("R1 masked", v, 32'h0);
    rd(8'h1C, v); check("R1 mask", v, 32'hFFFF_FFFF);
    rd(8'h14, v); check("R1 gate", v, 32'h0);
    rd(8'h4C, v); check("R1 cond", v, 32'h0);
  endtask

  task automatic t_layout();
    logic [31:0] v;
    wr(8'h4C, 32'h7654_3210);
    rd(8'h4C, v); check("R2 cond readback", v, 32'h7654_3210);
    rd(8'h48, v); check("R2 neighbour untouched", v, 32'h0);
    wr(8'h14, 32'hA5A5_A5A5);
    rd(8'h14, v); check("R2 gate readback", v, 32'hA5A5_A5A5);
    wr(8'h14, 32'h0);
    wr(8'h4C, 32'h0);
  endtask

  task automatic t_rise_latency();
    logic [31:0] v;
    wr(8'h40, 32'h0);
    wr(8'h14, 32'h1);
    wr(8'h18, 32'h1);
    @(negedge clk); pins = 32'h1;
    repeat (3) @(posedge clk); #1;
    check("R11 irq not yet", {31'h0, irq[0]}, 32'h0);
    @(posedge clk); #1;
    check("R11 irq on fourth edge", {31'h0, irq[0]}, 32'h1);
    set_pins(32'h0); idle(4);
    rd(8'h20, v); check("R3 edge held", v, 32'h1);
    wr(8'h28, 32'h1);
    rd(8'h20, v); check("R3 cleared", v, 32'h0);
    tidy();
  endtask

  task automatic t_fall_any();
    logic [31:0] v;
    wr(8'h40, 32'h0000_0410);
    wr(8'h14, 32'h6);
    set_pins(32'h6); idle(4);
    rd(8'h20, v); check("R4 rise: only either-edge pin", v, 32'h4);
    wr(8'h28, 32'h6);
    set_pins(32'h0); idle(4);
    rd(8'h20, v); check("R4 fall: both pins", v, 32'h6);
    tidy();
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(8'h40, 32'h0003_2000);
    wr(8'h14, 32'h18);
    idle(2);
    rd(8'h20, v); check("R5 low level latched", v, 32'h10);
    wr(8'h28, 32'h10);
    rd(8'h20, v); check("R5 read right after clear", v, 32'h0);
    rd(8'h20, v); check("R5 re-asserted", v, 32'h10);
    set_pins(32'h18); idle(4);
    wr(8'h28, 32'h18);
    idle(3);
    rd(8'h20, v); check("R5 only high-level pin returns", v, 32'h08);
    tidy();
  endtask

  task automatic t_gate();
    logic [31:0] v;
    wr(8'h40, 32'h0);
    set_pins(32'h20); idle(4);
    rd(8'h20, v); check("R6 gated pin ignored", v, 32'h0);
    set_pins(32'h0); idle(4);
    wr(8'h14, 32'h20);
    set_pins(32'h20); idle(4);
    wr(8'h14, 32'h0);
    idle(2);
    rd(8'h20, v); check("R6 pending kept after gate closes", v, 32'h20);
    tidy();
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(8'h40, 32'h0);
    wr(8'h48, 32'h0);
    wr(8'h14, 32'h0010_0040);
    set_pins(32'h0010_0040); idle(4);
    rd(8'h20, v); check("R9 raw", v, 32'h0010_0040);
    rd(8'h24, v); check("R9 masked all masked", v, 32'h0);
    check("R10 irq while masked", {30'h0, irq}, 32'h0);
    wr(8'h18, 32'h40); idle(1);
    check("R10 low request", {30'h0, irq}, 32'h1);
    rd(8'h1C, v); check("R7 mask after unmask", v, 32'hFFFF_FFBF);
    wr(8'h18, 32'h0);
    rd(8'h1C, v); check("R7 zero unmask no effect", v, 32'hFFFF_FFBF);
    wr(8'h18, 32'h0010_0000); idle(1);
    check("R10 both requests", {30'h0, irq}, 32'h3);
    wr(8'h1C, 32'h40); idle(1);
    check("R10 only high request", {30'h0, irq}, 32'h2);
    rd(8'h1C, v); check("R7 mask set", v, 32'hFFEF_FFFF);
    wr(8'h1C, 32'h0);
    rd(8'h1C, v); check("R7 zero mask no effect", v, 32'hFFEF_FFFF);
    rd(8'h24, v); check("R9 masked", v, 32'h0010_0000);
    wr(8'h28, 32'h0);
    rd(8'h20, v); check("R8 zero clear no effect", v, 32'h0010_0040);
    wr(8'h28, 32'h0010_0000); idle(1);
    rd(8'h20, v); check("R8 clear one pin", v, 32'h40);
    check("R10 requests drop", {30'h0, irq}, 32'h0);
    tidy();
  endtask

  task automatic t_codes();
    logic [31:0] v;
    wr(8'h40, 32'h5000_0000);
    wr(8'h44, 32'h0000_0008);
    rd(8'h44, v); check("R12 async flag stored", v, 32'h8);
    wr(8'h14, 32'h180);
    set_pins(32'h180); idle(4);
    set_pins(32'h100); idle(4);
    rd(8'h20, v); check("R12 code 5 silent, code 8 rises", v, 32'h100);
    tidy();
  endtask

  task automatic t_reprogram();
    logic [31:0] v;
    wr(8'h44, 32'h0000_0000);
    wr(8'h14, 32'h200);
    set_pins(32'h200); idle(4);
    wr(8'h28, 32'h200);
    wr(8'h14, 32'h0);
    wr(8'h44, 32'h0000_0030);
    wr(8'h28, 32'h200);
    wr(8'h14, 32'h200);
    idle(4);
    rd(8'h20, v); check("R13 no spurious after change to level low", v, 32'h0);
    wr(8'h14, 32'h0);
    wr(8'h44, 32'h0000_0010);
    wr(8'h28, 32'h200);
    wr(8'h14, 32'h200);
    idle(4);
    rd(8'h20, v); check("R13 no spurious after change to fall", v, 32'h0);
    set_pins(32'h0); idle(4);
    rd(8'h20, v); check("R13 new code active", v, 32'h200);
    tidy();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_layout();
    t_rise_latency();
    t_fall_any();
    t_level();
    t_gate();
    t_mask();
    t_codes();
    t_reprogram();
    finish_run();
  end
endmodule